// File: doc/BRIEF.md
# Serial-Controlled Stereo Attenuator with Soft Mute

This block sits in front of a stereo audio path and scales two signed sample streams by a common linear gain. A slow three-wire control port carries 8-bit command words from a host controller. Each word is either a 7-bit gain code or a pair of de-emphasis selection bits, depending on its most significant bit. The gain is code/127, so code 127 passes samples unchanged and code 0 silences them. The de-emphasis selection is only passed on to a downstream filter.

A mode input gives the same three control lines a second, static meaning. In parallel mode two of the lines drive the de-emphasis selection directly. The third line requests a soft mute, which steps the gain down to silence in 64 equal steps and back up again when the request is withdrawn. A request edge that arrives while a ramp is running is discarded. All three control lines are asynchronous to the system clock. They are synchronized, and their edges are detected in the clock domain.

Top module: `ctl_attenuator`

## Requirements
- R1: In serial mode (`par_mode` = 0) a bit is taken from `ctl_data` on each rising edge of `ctl_shift`. The first bit shifted in becomes bit 0 of the command word and the eighth becomes bit 7.
- R2: A shifted word takes effect only on a rising edge of `ctl_load`. Shifting bits without a load edge leaves the outputs unchanged.
- R3: A loaded word with bit 7 = 0 sets the gain code to bits 6..0 and leaves `deemph_sel` unchanged.
- R4: A loaded word with bit 7 = 1 sets `deemph_sel[1]` from bit 6 and `deemph_sel[0]` from bit 5, and leaves the gain code unchanged. The encoding is 11 = 32 kHz, 10 = 48 kHz, 01 = 44.1 kHz, 00 = off.
- R5: Each output sample equals the input sample times code/127, rounded to the nearest integer (halves cannot occur). The output is registered one clock after the input. Code 127 gives unity gain and code 0 gives zero.
- R6: After reset the gain code is 127, `deemph_sel` is 00 and the outputs are zero.
- R7: In parallel mode `deemph_sel` equals {`ctl_load`, `ctl_shift`} after synchronization. The serial gain code and de-emphasis setting are held, and they apply again on return to serial mode.
- R8: In parallel mode a rising edge on `ctl_data` starts a ramp of 64 steps, one every STEP_CYCLES clocks. After k steps the gain code is max(0, 127 - 2k), reaching zero after step 64.
- R9: A falling edge on `ctl_data` while fully muted ramps the code back up along the same steps to 127.
- R10: Edges on `ctl_data` that arrive while a ramp is in progress are ignored. The ramp finishes at its original target whatever level the input has.
- R11: Both channels are always scaled by the same gain code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_mode | input | 1 | 1 = parallel (static pin) control, 0 = serial command control |
| ctl_load | input | 1 | Serial: word load strobe. Parallel: de-emphasis select bit 1 |
| ctl_shift | input | 1 | Serial: shift clock. Parallel: de-emphasis select bit 0 |
| ctl_data | input | 1 | Serial: command data bit. Parallel: soft-mute request |
| in_left | input | SAMPLE_W | Left sample, two's complement |
| in_right | input | SAMPLE_W | Right sample, two's complement |
| out_left | output | SAMPLE_W | Scaled left sample |
| out_right | output | SAMPLE_W | Scaled right sample |
| deemph_sel | output | 2 | De-emphasis selection for the downstream filter |

## Verification
Several properties are checked on every clock:
- the ramp level moves by at most one step per clock;
- an idle ramp rests only at full gain or full mute;
- a code of 127 reproduces, and a code of 0 zeroes, the previous cycle's inputs on both channels;
- the de-emphasis output holds in serial mode unless a word is loaded.

Other behaviours need the bench's scenarios. These are the exact rounded product for every one of the 128 codes, the bit order of the serial word, and the rule that shifting without a load does nothing. The bench also covers the duration and monotonic shape of a mute ramp and the discarding of a request edge in the middle of a ramp.

// File: rtl/atten_pkg.sv
package atten_pkg;

   // de-emphasis selection as seen by the downstream filter
   typedef enum logic [1:0] {
      DEEMPH_OFF  = 2'b00,
      DEEMPH_44K1 = 2'b01,
      DEEMPH_48K  = 2'b10,
      DEEMPH_32K  = 2'b11
   } deemph_e;

   // ramp direction
   typedef enum logic {
      RAMP_UP   = 1'b0,
      RAMP_DOWN = 1'b1
   } ramp_dir_e;

endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain_q;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[g] <= '0;
            else        chain_q[g] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[g] <= '0;
            else        chain_q[g] <= chain_q[g-1];
         end
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/atten_serial_rx.sv
module atten_serial_rx #(
   parameter int CMD_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             shift_s,
   input  logic             load_s,
   input  logic             data_s,
   output logic [CMD_W-1:0] word,
   output logic             word_stb
);
   logic             shift_prev_q;
   logic             load_prev_q;
   logic [CMD_W-1:0] sreg_q;
   logic             shift_rise;

   assign shift_rise = shift_s & ~shift_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_prev_q <= 1'b0;
         load_prev_q  <= 1'b0;
         sreg_q       <= '0;
      end else begin
         shift_prev_q <= shift_s;
         load_prev_q  <= load_s;
         // first bit travels down to bit 0, last bit lands in the top bit
         if (en && shift_rise) sreg_q <= {data_s, sreg_q[CMD_W-1:1]};
      end
   end

   assign word     = sreg_q;
   assign word_stb = en & load_s & ~load_prev_q;
endmodule

// File: rtl/atten_cmd_reg.sv
module atten_cmd_reg
   import atten_pkg::*;
#(
   parameter int CODE_W = 7,
   localparam int CMD_W = CODE_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CMD_W-1:0]  word,
   input  logic              word_stb,
   output logic [CODE_W-1:0] att_code,
   output deemph_e           deemph
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         att_code <= '1;
         deemph   <= DEEMPH_OFF;
      end else if (word_stb) begin
         if (!word[CMD_W-1]) att_code <= word[CODE_W-1:0];
         else                deemph   <= deemph_e'(word[CMD_W-2 -: 2]);
      end
   end
endmodule

// File: rtl/atten_mute_ramp.sv
module atten_mute_ramp
   import atten_pkg::*;
#(
   parameter int CODE_W      = 7,
   parameter int STEPS       = 64,
   parameter int STEP_CYCLES = 15625,
   localparam int LVL_W = $clog2(STEPS + 1),
   localparam int TMR_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              mute_s,
   output logic [CODE_W-1:0] code,
   output logic              busy,
   output logic [LVL_W-1:0]  level
);
   localparam int FULL  = (1 << CODE_W) - 1;
   localparam int STEP  = (1 << CODE_W) / STEPS;
   localparam int DW    = CODE_W + LVL_W + 1;

   logic             prev_q;
   ramp_dir_e        dir_q;
   logic [TMR_W-1:0] tmr_q;
   logic             rise, fall;
   logic [DW-1:0]    drop_w;

   assign rise = mute_s & ~prev_q;
   assign fall = ~mute_s & prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         dir_q  <= RAMP_UP;
         tmr_q  <= '0;
         level  <= '0;
         busy   <= 1'b0;
      end else if (!en) begin
         prev_q <= 1'b0;
         dir_q  <= RAMP_UP;
         tmr_q  <= '0;
         level  <= '0;
         busy   <= 1'b0;
      end else begin
         prev_q <= mute_s;
         if (!busy) begin
            tmr_q <= '0;
            if (rise && level == '0) begin
               busy  <= 1'b1;
               dir_q <= RAMP_DOWN;
            end else if (fall && level == LVL_W'(STEPS)) begin
               busy  <= 1'b1;
               dir_q <= RAMP_UP;
            end
         end else if (tmr_q == TMR_W'(STEP_CYCLES - 1)) begin
            tmr_q <= '0;
            if (dir_q == RAMP_DOWN) begin
               level <= level + 1'b1;
               if (level == LVL_W'(STEPS - 1)) busy <= 1'b0;
            end else begin
               level <= level - 1'b1;
               if (level == LVL_W'(1)) busy <= 1'b0;
            end
         end else begin
            tmr_q <= tmr_q + 1'b1;
         end
      end
   end

   always_comb begin
      drop_w = DW'(level) * DW'(STEP);
      if (drop_w > DW'(FULL)) code = '0;
      else                    code = CODE_W'(DW'(FULL) - drop_w);
   end
endmodule

// File: rtl/atten_scale.sv
module atten_scale #(
   parameter int SAMPLE_W      = 16,
   parameter int CODE_W        = 7,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] sample,
   input  logic [CODE_W-1:0]   code,
   output logic [SAMPLE_W-1:0] scaled
);
   localparam int PROD_W = SAMPLE_W + CODE_W + 1;
   localparam logic [PROD_W-1:0] FULL_P = PROD_W'((1 << CODE_W) - 1);
   localparam logic [PROD_W-1:0] HALF_P = PROD_W'(((1 << CODE_W) - 1) / 2);

   logic [PROD_W-1:0] prod, mag, quo, res;
   logic              neg;

   always_comb begin
      // low PROD_W bits of the two's-complement product
      prod = {{(CODE_W+1){sample[SAMPLE_W-1]}}, sample} * {{(SAMPLE_W+1){1'b0}}, code};
      neg  = prod[PROD_W-1];
      mag  = neg ? (~prod + 1'b1) : prod;
   end

   if (ROUND_NEAREST) begin : g_round
      assign quo = (mag + HALF_P) / FULL_P;
   end else begin : g_trunc
      assign quo = mag / FULL_P;
   end

   assign res = neg ? (~quo + 1'b1) : quo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scaled <= '0;
      else        scaled <= res[SAMPLE_W-1:0];
   end
endmodule

// File: rtl/ctl_attenuator.sv
module ctl_attenuator
   import atten_pkg::*;
#(
   parameter int SAMPLE_W      = 16,
   parameter int CODE_W        = 7,
   parameter int SYNC_STAGES   = 2,
   parameter int RAMP_STEPS    = 64,
   parameter int STEP_CYCLES   = 15625,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                par_mode,
   input  logic                ctl_load,
   input  logic                ctl_shift,
   input  logic                ctl_data,
   input  logic [SAMPLE_W-1:0] in_left,
   input  logic [SAMPLE_W-1:0] in_right,
   output logic [SAMPLE_W-1:0] out_left,
   output logic [SAMPLE_W-1:0] out_right,
   output logic [1:0]          deemph_sel
);
   localparam int CMD_W  = CODE_W + 1;
   localparam int LVL_W  = $clog2(RAMP_STEPS + 1);
   localparam int NUM_CH = 2;

   if (SAMPLE_W < 2) begin : g_bad_sample
      $error("SAMPLE_W must be at least 2");
   end
   if (CODE_W < 3) begin : g_bad_code
      $error("CODE_W must be at least 3");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (RAMP_STEPS < 1 || RAMP_STEPS > (1 << CODE_W) || ((1 << CODE_W) % RAMP_STEPS) != 0) begin : g_bad_steps
      $error("RAMP_STEPS must divide 2**CODE_W");
   end
   if (STEP_CYCLES < 1) begin : g_bad_cycles
      $error("STEP_CYCLES must be positive");
   end

   logic              load_s, shift_s, data_s;
   logic [CMD_W-1:0]  word;
   logic              word_stb;
   logic [CODE_W-1:0] att_code;
   deemph_e           deemph_q;
   logic [CODE_W-1:0] ramp_code;
   logic              ramp_busy;
   logic [LVL_W-1:0]  ramp_level;
   logic [CODE_W-1:0] eff_code;

   logic [NUM_CH-1:0][SAMPLE_W-1:0] ch_in, ch_out;

   atten_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ctl_load, ctl_shift, ctl_data}),
      .q     ({load_s, shift_s, data_s})
   );

   atten_serial_rx #(.CMD_W(CMD_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (~par_mode),
      .shift_s  (shift_s),
      .load_s   (load_s),
      .data_s   (data_s),
      .word     (word),
      .word_stb (word_stb)
   );

   atten_cmd_reg #(.CODE_W(CODE_W)) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .word     (word),
      .word_stb (word_stb),
      .att_code (att_code),
      .deemph   (deemph_q)
   );

   atten_mute_ramp #(
      .CODE_W      (CODE_W),
      .STEPS       (RAMP_STEPS),
      .STEP_CYCLES (STEP_CYCLES)
   ) u_ramp (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (par_mode),
      .mute_s (data_s),
      .code   (ramp_code),
      .busy   (ramp_busy),
      .level  (ramp_level)
   );

   assign eff_code   = par_mode ? ramp_code : att_code;
   assign deemph_sel = par_mode ? {load_s, shift_s} : deemph_q;

   assign ch_in[0] = in_left;
   assign ch_in[1] = in_right;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      atten_scale #(
         .SAMPLE_W      (SAMPLE_W),
         .CODE_W        (CODE_W),
         .ROUND_NEAREST (ROUND_NEAREST)
      ) u_scale (
         .clk    (clk),
         .rst_n  (rst_n),
         .sample (ch_in[c]),
         .code   (eff_code),
         .scaled (ch_out[c])
      );
   end

   assign out_left  = ch_out[0];
   assign out_right = ch_out[1];
endmodule

// File: rtl/ctl_attenuator_chk.sv
module ctl_attenuator_chk #(
   parameter int SAMPLE_W   = 16,
   parameter int CODE_W     = 7,
   parameter int RAMP_STEPS = 64,
   localparam int LVL_W = $clog2(RAMP_STEPS + 1)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                par_mode,
   input logic                word_stb,
   input logic [CODE_W-1:0]   eff_code,
   input logic                ramp_busy,
   input logic [LVL_W-1:0]    ramp_level,
   input logic [SAMPLE_W-1:0] in_left,
   input logic [SAMPLE_W-1:0] in_right,
   input logic [SAMPLE_W-1:0] out_left,
   input logic [SAMPLE_W-1:0] out_right,
   input logic [1:0]          deemph_sel
);
   localparam logic [CODE_W-1:0] FULL = '1;

   assert_unity_gain_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_code == FULL) |=> (out_left == $past(in_left) && out_right == $past(in_right)));

   assert_zero_gain_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_code == '0) |=> (out_left == '0 && out_right == '0));

   assert_deemph_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!par_mode && !word_stb) |=> (par_mode || $stable(deemph_sel)));

   assert_ramp_single_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (par_mode && $past(par_mode)) |->
         (ramp_level == $past(ramp_level) ||
          ramp_level == $past(ramp_level) + 1'b1 ||
          ramp_level + 1'b1 == $past(ramp_level)));

   assert_idle_endpoint_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (par_mode && !ramp_busy) |-> (ramp_level == '0 || ramp_level == LVL_W'(RAMP_STEPS)));
endmodule

bind ctl_attenuator ctl_attenuator_chk #(
   .SAMPLE_W   (SAMPLE_W),
   .CODE_W     (CODE_W),
   .RAMP_STEPS (RAMP_STEPS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .par_mode   (par_mode),
   .word_stb   (word_stb),
   .eff_code   (eff_code),
   .ramp_busy  (ramp_busy),
   .ramp_level (ramp_level),
   .in_left    (in_left),
   .in_right   (in_right),
   .out_left   (out_left),
   .out_right  (out_right),
   .deemph_sel (deemph_sel)
);

// File: tb/sim_ctl_attenuator.sv
module sim_ctl_attenuator;
   localparam int SW   = 16;
   localparam int CW   = 7;
   localparam int SC   = 3;
   localparam int FULL = (1 << CW) - 1;
   localparam int HALF = FULL / 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          par_mode = 1'b0;
   logic          ctl_load = 1'b0, ctl_shift = 1'b0, ctl_data = 1'b0;
   logic [SW-1:0] in_left = '0, in_right = '0;
   logic [SW-1:0] out_left, out_right;
   logic [1:0]    deemph_sel;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   always #10 clk = ~clk;

   ctl_attenuator #(.STEP_CYCLES(SC)) u0 (
      .clk(clk), .rst_n(rst_n), .par_mode(par_mode),
      .ctl_load(ctl_load), .ctl_shift(ctl_shift), .ctl_data(ctl_data),
      .in_left(in_left), .in_right(in_right),
      .out_left(out_left), .out_right(out_right), .deemph_sel(deemph_sel)
   );

   localparam int SAMP [6] = '{0, 1, -1, 32767, -32768, 12345};

   function automatic int exp_scale(int s, int c);
      int p;
      p = s * c;
      if (p >= 0) return (p + HALF) / FULL;
      return -((-p + HALF) / FULL);
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   task automatic wait_clk(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic shift_bits(logic [7:0] w);
      for (int i = 0; i < 8; i++) begin
         ctl_data = w[i];
         wait_clk(4);
         ctl_shift = 1'b1;
         wait_clk(4);
         ctl_shift = 1'b0;
         wait_clk(4);
      end
   endtask

   task automatic pulse_load();
      ctl_load = 1'b1;
      wait_clk(6);
      ctl_load = 1'b0;
      wait_clk(6);
   endtask

   task automatic send_word(logic [7:0] w);
      shift_bits(w);
      pulse_load();
   endtask

   task automatic set_in(int l, int r);
      in_left  = SW'(l);
      in_right = SW'(r);
      wait_clk(2);
   endtask

   function automatic int sl();
      return int'($signed(out_left));
   endfunction
   function automatic int sr();
      return int'($signed(out_right));
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
   end

   initial begin
      in_left  = SW'(1000);
      in_right = SW'(-1000);
      wait_clk(3);
      // R6: outputs cleared while reset holds
      chk("R6 out_left in reset", sl(), 0);
      rst_n = 1'b1;
      wait_clk(4);
      chk("R6 deemph after reset", int'(deemph_sel), 0);
      chk("R6 unity left after reset", sl(), 1000);
      chk("R6 unity right after reset", sr(), -1000);

      // R1 R3 R5 R11: exhaustive sweep of every gain code
      for (int code = 0; code <= FULL; code++) begin
         send_word({1'b0, 7'(code)});
         for (int i = 0; i < 6; i++) begin
            set_in(SAMP[i], SAMP[(i + 3) % 6]);
            chk($sformatf("R5 R1 left code=%0d", code), sl(), exp_scale(SAMP[i], code));
            chk($sformatf("R11 right code=%0d", code), sr(), exp_scale(SAMP[(i + 3) % 6], code));
         end
      end
      chk("R3 deemph untouched by gain words", int'(deemph_sel), 0);

      // R2: shifting without a load changes nothing
      set_in(20000, -7000);
      shift_bits(8'h10);
      wait_clk(4);
      chk("R2 no load left", sl(), 20000);
      chk("R2 no load right", sr(), -7000);
      pulse_load();
      chk("R2 after load", sl(), exp_scale(20000, 16));

      // R4: de-emphasis words, every encoding, gain held
      for (int d = 0; d < 4; d++) begin
         send_word({1'b1, 2'(3 - d), 5'b10101});
         chk($sformatf("R4 deemph sel=%0d", 3 - d), int'(deemph_sel), 3 - d);
         chk("R4 gain held", sl(), exp_scale(20000, 16));
      end
      send_word(8'b1_10_00000);
      send_word(8'h40);
      chk("R3 deemph kept after gain word", int'(deemph_sel), 2);
      chk("R3 new gain", sl(), exp_scale(20000, 64));

      // R7: parallel mode pin-driven de-emphasis
      par_mode = 1'b1;
      wait_clk(4);
      chk("R7 parallel full gain", sl(), 20000);
      for (int d = 0; d < 4; d++) begin
         ctl_load  = d[1];
         ctl_shift = d[0];
         wait_clk(4);
         chk($sformatf("R7 parallel deemph=%0d", d), int'(deemph_sel), d);
      end
      ctl_load = 1'b0;
      ctl_shift = 1'b0;
      wait_clk(4);

      // R8: ramp down, monotonic, timed
      begin
         int prev;
         bit mono;
         prev = sl();
         mono = 1'b1;
         ctl_data = 1'b1;
         for (int t = 1; t <= 220; t++) begin
            wait_clk(1);
            if (sl() > prev || sl() < 0) mono = 1'b0;
            prev = sl();
            if (t == 96) chk("R8 mid ramp between", (sl() > 0 && sl() < 20000) ? 1 : 0, 1);
            if (t == 180) chk("R8 still ramping at 180", (sl() > 0) ? 1 : 0, 1);
         end
         chk("R8 monotonic fall", int'(mono), 1);
         chk("R8 muted left", sl(), 0);
         chk("R8 muted right", sr(), 0);
      end

      // R9 R10: ramp up, with a request edge in the middle that is ignored
      ctl_data = 1'b0;
      wait_clk(30);
      chk("R9 partially up", (sl() > 0 && sl() < 20000) ? 1 : 0, 1);
      ctl_data = 1'b1;
      wait_clk(270);
      chk("R10 ramp ended at full gain", sl(), 20000);
      chk("R10 right full gain", sr(), -7000);
      // idle at full gain, request held high: a fall from here is ignored
      ctl_data = 1'b0;
      wait_clk(40);
      chk("R10 fall at full gain ignored", sl(), 20000);
      ctl_data = 1'b1;
      wait_clk(260);
      chk("R8 second mute", sl(), 0);
      ctl_data = 1'b0;
      wait_clk(260);
      chk("R9 restored left", sl(), 20000);

      // R7: serial setting returns on leaving parallel mode
      par_mode = 1'b0;
      wait_clk(4);
      chk("R7 serial gain restored", sl(), exp_scale(20000, 64));
      chk("R7 serial deemph restored", int'(deemph_sel), 2);

      report();
   end
endmodule